// File: doc/BRIEF.md
# Two-Strike Interrupt Watchdog Timer

This block pairs a microsecond-tick down-counter with a watchdog monitor that treats the counter's expiry interrupt as a strike. Each time the programmed count runs out, an interrupt flag is raised, and software acknowledges it through a register write. If the counter runs out again while the earlier interrupt is still unacknowledged, the monitor issues a system reset pulse of fixed length. Software therefore programs the counter to half of the watchdog timeout it wants.

Access is through a small word-addressed register port with a write strobe and a combinational read path. Three locations exist: timer configuration (count, enable, auto-reload), interrupt acknowledge/status, and watchdog control (enable, strike source, reset enable). The tick input is a single-cycle pulse, one per microsecond, supplied from outside. Writing zero to both the timer configuration and the watchdog control shuts the whole function down.

Top module: `strike_wdt`

## Requirements
- R1: Offset 0x0 is the timer configuration: bit 31 enables counting, bit 30 selects auto-reload, bits CNT_W-1:0 hold the count in ticks. A read returns those fields, with all other bits zero.
- R2: After a write of count N (N ≥ 1) with bit 31 set, the Nth following tick is an expiry, and irq_o is high from the clock cycle after that tick.
- R3: With auto-reload set, the counter reloads N on expiry and expires again every N ticks. With it clear, the counter stops at zero and does not expire again.
- R4: Writing a 1 to bit 30 at offset 0x4 clears the interrupt flag, and a 0 in that bit has no effect. An expiry in the same cycle as the clear keeps the flag set. Bit 30 of a read at 0x4 shows the flag.
- R5: Offset 0x8 is the watchdog control: bit 5 enables, bit 4 selects the strike source (0 = this timer, 1 = no source), bit 2 enables reset. A read returns those three bits, with all other bits zero.
- R6: With bit 5 = 1, bit 4 = 0 and bit 2 = 1, an expiry while an earlier expiry's interrupt is still unacknowledged drives sys_rst_o high from the next cycle for exactly RST_PULSE cycles.
- R7: The strike that fires the reset also clears the interrupt flag and the strike state. Two further expiries are then needed for another reset.
- R8: An expiry after the previous interrupt was acknowledged, including an acknowledgement in the same cycle, starts a new strike and gives no reset.
- R9: sys_rst_o is never high while the watchdog enable is 0. Clearing it ends a running pulse on the next cycle, and an armed strike is discarded, so the first expiry after re-enabling causes no reset.
- R10: With bit 4 = 1 or bit 2 = 0, expiries raise the interrupt as usual but never cause a reset.
- R11: After zero is written to both offset 0x0 and offset 0x8, ticks cause no expiry, no interrupt and no reset.
- R12: After reset, all three register reads return zero, and irq_o and sys_rst_o are low.
- R13: An enabled count of zero never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Pending timer interrupt flag |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bench builds the block with CNT_W = 12 and RST_PULSE = 4. A 12-bit count field leaves bits 29:12 of the configuration word unused, so the readback can show that they are dropped. A four-cycle pulse lets the bench measure its full length and cut it short by disabling. Counts of one to three ticks bring expiries, double strikes and acknowledge-versus-expiry collisions within a few cycles.

// File: rtl/strike_wdt_pkg.sv
package strike_wdt_pkg;

    // register byte offsets
    localparam logic [7:0] OFS_TMR_CFG = 8'h00;
    localparam logic [7:0] OFS_TMR_IRQ = 8'h04;
    localparam logic [7:0] OFS_WD_CTRL = 8'h08;

    // bit positions inside the register words
    localparam int BIT_TMR_EN   = 31;
    localparam int BIT_TMR_AUTO = 30;
    localparam int BIT_IRQ_ACK  = 30;
    localparam int BIT_WD_EN    = 5;
    localparam int BIT_WD_SRC   = 4;
    localparam int BIT_WD_RST   = 2;

    typedef struct packed {
        logic en;
        logic src;
        logic rst_en;
    } wd_ctrl_t;

    typedef struct packed {
        logic cfg_wr;
        logic irq_ack;
        logic ctrl_wr;
    } bus_strobe_t;

endpackage

// File: rtl/strike_wdt_regs.sv
module strike_wdt_regs
    import strike_wdt_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              tmr_en,
    input  logic              tmr_auto,
    input  logic [CNT_W-1:0]  tmr_period,
    input  logic              irq_pend,
    output bus_strobe_t       stb,
    output logic              cfg_en,
    output logic              cfg_auto,
    output logic [CNT_W-1:0]  cfg_period,
    output wd_ctrl_t          ctrl,
    output wd_ctrl_t          ctrl_nx,
    output logic [31:0]       bus_rdata
);

    localparam logic [31:0] CNT_MASK  = (32'(1) << CNT_W) - 32'(1);
    localparam logic [31:0] USED_MASK = CNT_MASK
                                      | (32'(1) << BIT_TMR_EN)
                                      | (32'(1) << BIT_TMR_AUTO)
                                      | (32'(1) << BIT_WD_EN)
                                      | (32'(1) << BIT_WD_SRC)
                                      | (32'(1) << BIT_WD_RST);

    typedef struct packed {
        wd_ctrl_t ctrl;
    } regs_state_t;

    regs_state_t s_d, s_q;
    logic        hit_cfg, hit_irq, hit_ctrl;
    logic        unused_wdata;

    assign unused_wdata = ^(bus_wdata & ~USED_MASK);

    always_comb begin
        hit_cfg  = (bus_addr == ADDR_W'(OFS_TMR_CFG));
        hit_irq  = (bus_addr == ADDR_W'(OFS_TMR_IRQ));
        hit_ctrl = (bus_addr == ADDR_W'(OFS_WD_CTRL));

        stb.cfg_wr  = bus_wr && hit_cfg;
        stb.irq_ack = bus_wr && hit_irq && bus_wdata[BIT_IRQ_ACK];
        stb.ctrl_wr = bus_wr && hit_ctrl;

        cfg_en     = bus_wdata[BIT_TMR_EN];
        cfg_auto   = bus_wdata[BIT_TMR_AUTO];
        cfg_period = bus_wdata[CNT_W-1:0];

        s_d = s_q;
        if (stb.ctrl_wr) begin
            s_d.ctrl.en     = bus_wdata[BIT_WD_EN];
            s_d.ctrl.src    = bus_wdata[BIT_WD_SRC];
            s_d.ctrl.rst_en = bus_wdata[BIT_WD_RST];
        end

        bus_rdata = '0;
        if (hit_cfg) begin
            bus_rdata[CNT_W-1:0]    = tmr_period;
            bus_rdata[BIT_TMR_EN]   = tmr_en;
            bus_rdata[BIT_TMR_AUTO] = tmr_auto;
        end else if (hit_irq) begin
            bus_rdata[BIT_IRQ_ACK]  = irq_pend;
        end else if (hit_ctrl) begin
            bus_rdata[BIT_WD_EN]    = s_q.ctrl.en;
            bus_rdata[BIT_WD_SRC]   = s_q.ctrl.src;
            bus_rdata[BIT_WD_RST]   = s_q.ctrl.rst_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl    = s_q.ctrl;
    assign ctrl_nx = s_d.ctrl;

endmodule

// File: rtl/strike_wdt_timer.sv
module strike_wdt_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cfg_wr,
    input  logic             cfg_en,
    input  logic             cfg_auto,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic             irq_ack,
    input  logic             kill,
    output logic             expire,
    output logic             en_o,
    output logic             auto_o,
    output logic [CNT_W-1:0] period_o,
    output logic             pend_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             en;
        logic             auto_rl;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } tmr_state_t;

    tmr_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        expire = 1'b0;

        if (cfg_wr) begin
            // a new configuration restarts the count from the full period
            s_d.en      = cfg_en;
            s_d.auto_rl = cfg_auto;
            s_d.period  = cfg_period;
            s_d.cnt     = cfg_period;
        end else if (s_q.en && tick && (s_q.cnt != '0)) begin
            if (s_q.cnt == ONE) begin
                expire = 1'b1;
                s_d.cnt = s_q.auto_rl ? s_q.period : '0;
            end else begin
                s_d.cnt = s_q.cnt - ONE;
            end
        end

        // a fresh expiry outranks an acknowledge; a reset strike outranks both
        s_d.pend = (s_q.pend && !irq_ack) || expire;
        if (kill) s_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_o     = s_q.en;
    assign auto_o   = s_q.auto_rl;
    assign period_o = s_q.period;
    assign pend_o   = s_q.pend;

endmodule

// File: rtl/strike_wdt_monitor.sv
module strike_wdt_monitor
    import strike_wdt_pkg::*;
#(
    parameter int RST_PULSE = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     expire,
    input  logic     irq_ack,
    input  wd_ctrl_t ctrl,
    input  wd_ctrl_t ctrl_nx,
    output logic     fire,
    output logic     sys_rst
);

    localparam int            PW       = $clog2(RST_PULSE + 1);
    localparam logic [PW-1:0] PULSE_LD = PW'(RST_PULSE);

    typedef struct packed {
        logic          armed;
        logic [PW-1:0] pulse;
    } mon_state_t;

    mon_state_t s_d, s_q;
    logic       live;

    always_comb begin
        live = ctrl.en && !ctrl.src && ctrl.rst_en;
        fire = live && expire && s_q.armed && !irq_ack;

        s_d = s_q;
        // first strike arms; an acknowledge or a leaving of the live state disarms
        s_d.armed = live && !fire && ((s_q.armed && !irq_ack) || expire);

        if (!ctrl_nx.en)              s_d.pulse = '0;
        else if (fire)                s_d.pulse = PULSE_LD;
        else if (s_q.pulse != '0)     s_d.pulse = s_q.pulse - PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sys_rst = (s_q.pulse != '0);

endmodule

// File: rtl/strike_wdt.sv
module strike_wdt
    import strike_wdt_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int RST_PULSE = 16,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);

    bus_strobe_t      stb_w;
    logic             cfg_en_w, cfg_auto_w;
    logic [CNT_W-1:0] cfg_period_w;
    wd_ctrl_t         ctrl_w, ctrl_nx_w;
    logic             tmr_en_w, tmr_auto_w;
    logic [CNT_W-1:0] tmr_period_w;
    logic             expire_w, fire_w;

    strike_wdt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .tmr_en     (tmr_en_w),
        .tmr_auto   (tmr_auto_w),
        .tmr_period (tmr_period_w),
        .irq_pend   (irq_o),
        .stb        (stb_w),
        .cfg_en     (cfg_en_w),
        .cfg_auto   (cfg_auto_w),
        .cfg_period (cfg_period_w),
        .ctrl       (ctrl_w),
        .ctrl_nx    (ctrl_nx_w),
        .bus_rdata  (bus_rdata)
    );

    strike_wdt_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (us_tick),
        .cfg_wr     (stb_w.cfg_wr),
        .cfg_en     (cfg_en_w),
        .cfg_auto   (cfg_auto_w),
        .cfg_period (cfg_period_w),
        .irq_ack    (stb_w.irq_ack),
        .kill       (fire_w),
        .expire     (expire_w),
        .en_o       (tmr_en_w),
        .auto_o     (tmr_auto_w),
        .period_o   (tmr_period_w),
        .pend_o     (irq_o)
    );

    strike_wdt_monitor #(.RST_PULSE(RST_PULSE)) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire_w),
        .irq_ack (stb_w.irq_ack),
        .ctrl    (ctrl_w),
        .ctrl_nx (ctrl_nx_w),
        .fire    (fire_w),
        .sys_rst (sys_rst_o)
    );

endmodule

// File: rtl/strike_wdt_chk.sv
module strike_wdt_chk
    import strike_wdt_pkg::*;
#(
    parameter int RST_PULSE = 16,
    parameter int ADDR_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              ack_bit,
    input logic              irq_o,
    input logic              sys_rst_o,
    input logic              expire,
    input logic              fire,
    input logic              wd_en
);

    localparam int           SW     = $clog2(RST_PULSE + 2) + 1;
    localparam logic [SW-1:0] SF_MAX = {SW{1'b1}};

    logic [SW-1:0] since_fire_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                     since_fire_q <= '0;
        else if (fire)                  since_fire_q <= '0;
        else if (sys_rst_o && since_fire_q != SF_MAX)
                                        since_fire_q <= since_fire_q + SW'(1);
        else if (!sys_rst_o)            since_fire_q <= '0;
    end

    // R9
    rst_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> wd_en);

    // R6
    rst_after_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> $past(irq_o));

    // R7
    rst_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> !irq_o);

    // R4
    ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_TMR_IRQ) && ack_bit && !expire) |=> !irq_o);

    // R2
    expire_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !fire) |=> irq_o);

    // R6
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> (since_fire_q < SW'(RST_PULSE)));

endmodule

bind strike_wdt strike_wdt_chk #(.RST_PULSE(RST_PULSE), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .ack_bit   (bus_wdata[strike_wdt_pkg::BIT_IRQ_ACK]),
    .irq_o     (irq_o),
    .sys_rst_o (sys_rst_o),
    .expire    (expire_w),
    .fire      (fire_w),
    .wd_en     (ctrl_w.en)
);

// File: tb/strike_wdt_test.sv
`timescale 1ns/1ps
module strike_wdt_test;

    localparam int CNT_W     = 12;
    localparam int RST_PULSE = 4;
    localparam int ADDR_W    = 4;
    localparam logic [31:0] ACK = 32'h4000_0000;

    typedef struct packed {
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic [31:0] rexp;
    } vec_t;

    // R1 rows 0-2, R5 rows 3-6, R4 row 7
    localparam vec_t VEC [0:7] = '{
        '{4'h0, 32'hC000_0123, 32'hC000_0123},
        '{4'h0, 32'h8FFF_F7AB, 32'h8000_07AB},
        '{4'h0, 32'h0000_0000, 32'h0000_0000},
        '{4'h8, 32'h0000_003F, 32'h0000_0034},
        '{4'h8, 32'hFFFF_FFCB, 32'h0000_0000},
        '{4'h8, 32'h0000_0024, 32'h0000_0024},
        '{4'h8, 32'h0000_0000, 32'h0000_0000},
        '{4'h4, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              us_tick = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_o, sys_rst_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    strike_wdt #(.CNT_W(CNT_W), .RST_PULSE(RST_PULSE), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; us_tick = tk;
        @(negedge clk);
        bus_wr = 1'b0; us_tick = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); us_tick = 1'b1;
            @(negedge clk); us_tick = 1'b0;
        end
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (sys_rst_o && n < 50) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_all();
        logic [31:0] d;
        int          n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 irq", 32'(irq_o), 0);
        chk("R12 rst", 32'(sys_rst_o), 0);
        rd(4'h0, d); chk("R12 cfg", d, 0);
        rd(4'h4, d); chk("R12 irqreg", d, 0);
        rd(4'h8, d); chk("R12 ctrl", d, 0);

        // R1 / R5 / R4 register table
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i].addr, VEC[i].wdata, 1'b0);
            rd(VEC[i].addr, d);
            chk($sformatf("R1/R4/R5 table row %0d", i), d, VEC[i].rexp);
        end

        // R2 one-shot count of 3
        wr(4'h0, 32'h8000_0003, 1'b0);
        ticks(2); chk("R2 before Nth tick", 32'(irq_o), 0);
        ticks(1); chk("R2 on Nth tick", 32'(irq_o), 1);
        rd(4'h4, d); chk("R4 status read", d, ACK);
        wr(4'h4, 32'h0, 1'b0); chk("R4 zero write ignored", 32'(irq_o), 1);
        wr(4'h4, ACK, 1'b0);   chk("R4 ack clears", 32'(irq_o), 0);
        ticks(5); chk("R3 one-shot stops", 32'(irq_o), 0);

        // R3 auto-reload count of 2
        wr(4'h0, 32'hC000_0002, 1'b0);
        ticks(2); chk("R3 first expiry", 32'(irq_o), 1);
        wr(4'h4, ACK, 1'b0);
        ticks(1); chk("R3 mid period", 32'(irq_o), 0);
        ticks(1); chk("R3 reload expiry", 32'(irq_o), 1);
        wr(4'h4, ACK, 1'b0);

        // R13 zero count never expires
        wr(4'h0, 32'hC000_0000, 1'b0);
        ticks(5); chk("R13 zero count", 32'(irq_o), 0);

        // R6 double strike
        wr(4'h8, 32'h24, 1'b0);
        wr(4'h0, 32'hC000_0002, 1'b0);
        ticks(2); chk("R6 first strike irq", 32'(irq_o), 1);
        chk("R6 first strike no rst", 32'(sys_rst_o), 0);
        ticks(1); chk("R6 between strikes", 32'(sys_rst_o), 0);
        ticks(1); chk("R6 second strike rst", 32'(sys_rst_o), 1);
        chk("R7 irq cleared by strike", 32'(irq_o), 0);
        pulse_len(n); chk("R6 pulse length", 32'(n), RST_PULSE);

        // R7 fresh pair needed
        ticks(2); chk("R7 one expiry after reset", 32'(sys_rst_o), 0);
        ticks(2); chk("R7 second expiry after reset", 32'(sys_rst_o), 1);
        pulse_len(n);

        // R8 acknowledged strike
        ticks(2); wr(4'h4, ACK, 1'b0);
        ticks(2); chk("R8 acked then expiry irq", 32'(irq_o), 1);
        chk("R8 acked then expiry no rst", 32'(sys_rst_o), 0);
        ticks(1);
        wr(4'h4, ACK, 1'b1);
        chk("R4 expiry beats ack", 32'(irq_o), 1);
        chk("R8 same-cycle ack no rst", 32'(sys_rst_o), 0);
        ticks(2); chk("R8 collision expiry armed", 32'(sys_rst_o), 1);
        pulse_len(n);

        // R10 source select and reset enable
        wr(4'h8, 32'h34, 1'b0);
        ticks(4); chk("R10 src=1 irq", 32'(irq_o), 1);
        chk("R10 src=1 no rst", 32'(sys_rst_o), 0);
        wr(4'h4, ACK, 1'b0);
        wr(4'h8, 32'h20, 1'b0);
        ticks(4); chk("R10 rst_en=0 no rst", 32'(sys_rst_o), 0);
        wr(4'h4, ACK, 1'b0);

        // R9 disable discards strike and aborts pulse
        wr(4'h8, 32'h24, 1'b0);
        ticks(2);
        wr(4'h8, 32'h00, 1'b0);
        wr(4'h8, 32'h24, 1'b0);
        ticks(2); chk("R9 discarded strike no rst", 32'(sys_rst_o), 0);
        chk("R9 irq still pending", 32'(irq_o), 1);
        ticks(2); chk("R9 rearmed strike rst", 32'(sys_rst_o), 1);
        wr(4'h8, 32'h00, 1'b0);
        chk("R9 disable aborts pulse", 32'(sys_rst_o), 0);
        ticks(4); chk("R9 disabled no rst", 32'(sys_rst_o), 0);

        // R11 full shutdown
        wr(4'h8, 32'h24, 1'b0);
        wr(4'h0, 32'h0, 1'b0);
        wr(4'h8, 32'h0, 1'b0);
        wr(4'h4, ACK, 1'b0);
        ticks(10);
        chk("R11 no irq", 32'(irq_o), 0);
        chk("R11 no rst", 32'(sys_rst_o), 0);
        rd(4'h0, d); chk("R11 cfg zero", d, 0);
        rd(4'h8, d); chk("R11 ctrl zero", d, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (50000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog (all requirements): actual hung expected done");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule